// File: doc/BRIEF.md
# Data-Link Bit-Oriented Message Receiver

This block watches the serial data-link channel of an extended-superframe line next to an HDLC receiver. It decides at every received bit whether the channel carries HDLC frames or short repeated bit-oriented messages, and it moves between the two modes on its own. A run of eight ones moves it into message mode. A flag pattern moves it back to HDLC mode. A single enable input turns the message receiver on or off. While it is off, the channel stays in HDLC mode.

In message mode each message repeats the same 16-bit shape: a byte of all ones used as a sync word, then a data byte that must start and end with a zero. After each sync the next eight bits are assembled with the earliest bit in the least-significant position. The byte is offered to the receive FIFO only if both edge bits are zero. A supervision window raises a one-cycle interrupt each time 32 received bits pass in message mode without a run of eight ones. The interrupt does not interrupt byte capture.

The bit input cannot be stalled: `in_valid` marks a bit and there is no ready signal on that side. The byte output is valid/ready. A byte stays on `out_data` with `out_valid` high until a cycle with `out_ready` high. A byte that completes while the slot is still occupied, and is not being accepted in that same cycle, is discarded. When the held byte is accepted in the same cycle that a new byte completes, the new byte takes the slot.

Top module: `dl_msg_rx`

## Requirements
- R1: While `en` is low, `msg_mode` is 0 from the next clock on. No byte is written and `irq` stays low whatever bits arrive. After reset `msg_mode`, `out_valid` and `irq` are 0.
- R2: With `en` high in HDLC mode, the bit that completes eight consecutive valid ones sets `msg_mode` to 1 in the following cycle. Seven ones followed by other bits do not.
- R3: In message mode, when the last eight valid bits in arrival order are 0,1,1,1,1,1,1,0 (at any bit alignment), `msg_mode` is 0 in the following cycle.
- R4: On every mode change the ones-run count and the sync search are cleared, so the run that caused entry is not used as sync. In message mode, the eight valid bits after the bit that brings the run to eight or more form the candidate byte.
- R5: A candidate byte is written only if its first received bit and its last received bit are both 0. Otherwise it is discarded.
- R6: The first received candidate bit appears at `out_data[0]` and the last at `out_data[7]`. `out_valid` rises in the cycle after the last candidate bit.
- R7: In message mode, the 32nd valid bit after the last bit at which the ones run was eight or more (or after entry) produces a one-cycle `irq` pulse in the next cycle, and the window starts over. Byte capture carries on across the pulse.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable. A byte completing in that state is dropped.
- R9: Cycles with `in_valid` low change neither the mode nor the ones run.
- R10: When the bit that ends a candidate byte also completes a flag, the flag wins: the mode returns to HDLC and no byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enables message-mode detection |
| in_valid | input | 1 | Marks a received line bit in this cycle |
| in_bit | input | 1 | Received line bit |
| msg_mode | output | 1 | 1 = message mode, 0 = HDLC mode |
| out_valid | output | 1 | Accepted message byte available |
| out_ready | input | 1 | FIFO takes the byte in this cycle |
| out_data | output | 8 | Message byte, first received bit in bit 0 |
| irq | output | 1 | One-cycle pulse when a supervision window expires |

## Verification
Flag recognition and byte completion can fall on the same bit, because a candidate byte of 0x7E is itself a flag. The bench sends a sync run followed by that byte. It then requires that the mode is HDLC and that the scoreboard receives no byte. A second overlap, a new byte completing while the output slot is held, is provoked by holding `out_ready` low across two messages. It is judged by checking that only the first byte ever reaches the scoreboard.

// File: rtl/dlmr_pkg.sv
package dlmr_pkg;
  localparam int unsigned FLAG_W   = 8;
  localparam logic [FLAG_W-1:0] FLAG_PAT = 8'h7E;

  typedef enum logic {
    MODE_HDLC = 1'b0,
    MODE_MSG  = 1'b1
  } mode_e;
endpackage

// File: rtl/dlmr_pattern.sv
// Ones-run counter and flag matcher over the received bit history.
module dlmr_pattern
  import dlmr_pkg::*;
#(
  parameter int unsigned RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  input  logic clr,
  output logic run_hit,
  output logic flag_hit
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0]     run_q;
  logic [FLAG_W-1:0] hist_q;
  logic [FLAG_W-1:0] hist_nxt;

  assign hist_nxt = {hist_q[FLAG_W-2:0], in_bit};
  assign run_hit  = in_valid && in_bit && (run_q >= CW'(RUN_LEN - 1));
  assign flag_hit = in_valid && (hist_nxt == FLAG_PAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      hist_q <= '1;
    end else begin
      if (in_valid) hist_q <= hist_nxt;
      if (clr) begin
        run_q <= '0;
      end else if (in_valid) begin
        if (!in_bit)                    run_q <= '0;
        else if (run_q != CW'(RUN_LEN)) run_q <= run_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/dlmr_window.sv
// Supervision window: pulses when WIN_BITS bits pass without a ones run.
module dlmr_window #(
  parameter int unsigned WIN_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic active,
  input  logic restart,
  output logic irq
);
  localparam int unsigned CW = $clog2(WIN_BITS);

  logic [CW-1:0] win_q;
  logic          at_end;
  logic          expire;

  assign at_end = (win_q == CW'(WIN_BITS - 1));
  assign expire = in_valid && active && !restart && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= expire;
      if (!active)
        win_q <= '0;
      else if (in_valid)
        win_q <= (restart || at_end) ? '0 : win_q + CW'(1);
    end
  end
endmodule

// File: rtl/dlmr_collect.sv
// Byte assembly after sync and edge-bit validation.
module dlmr_collect #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_bit,
  input  logic              active,
  input  logic              sync,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int unsigned IW = $clog2(BYTE_W);

  logic              busy_q;
  logic [IW-1:0]     idx_q;
  logic [BYTE_W-1:0] shr_q;
  logic              last;

  assign byte_val = {in_bit, shr_q[BYTE_W-1:1]};
  assign last     = (idx_q == IW'(BYTE_W - 1));
  assign byte_stb = in_valid && active && busy_q && last &&
                    !byte_val[0] && !in_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      shr_q  <= '0;
    end else if (!active) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (in_valid) begin
      if (!busy_q) begin
        if (sync) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
        end
      end else begin
        shr_q <= byte_val;
        if (last) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dlmr_slot.sv
// One-entry valid/ready output slot; a new byte is dropped while the slot is held.
module dlmr_slot #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data
);
  logic take;

  assign take = load_req && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= load_val;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dl_msg_rx.sv
module dl_msg_rx
  import dlmr_pkg::*;
#(
  parameter int unsigned RUN_LEN  = 8,
  parameter int unsigned WIN_BITS = 32,
  parameter int unsigned BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              msg_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              irq
);
  mode_e             mode_q;
  mode_e             mode_nxt;
  logic              chg;
  logic              active;
  logic              run_hit;
  logic              flag_hit;
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_val;

  // Mode selection: disable forces HDLC, flag returns to HDLC (R3, R10).
  always_comb begin
    mode_nxt = mode_q;
    if (!en)
      mode_nxt = MODE_HDLC;
    else if (mode_q == MODE_HDLC && run_hit)
      mode_nxt = MODE_MSG;
    else if (mode_q == MODE_MSG && flag_hit)
      mode_nxt = MODE_HDLC;
  end

  assign chg    = (mode_nxt != mode_q);
  assign active = (mode_q == MODE_MSG) && !chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_HDLC;
    else        mode_q <= mode_nxt;
  end

  assign msg_mode = (mode_q == MODE_MSG);

  dlmr_pattern #(.RUN_LEN(RUN_LEN)) u_pattern (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .clr      (chg),
    .run_hit  (run_hit),
    .flag_hit (flag_hit)
  );

  dlmr_collect #(.BYTE_W(BYTE_W)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .active   (active),
    .sync     (run_hit),
    .byte_stb (byte_stb),
    .byte_val (byte_val)
  );

  dlmr_window #(.WIN_BITS(WIN_BITS)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .active   (active),
    .restart  (run_hit),
    .irq      (irq)
  );

  dlmr_slot #(.BYTE_W(BYTE_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (byte_stb),
    .load_val  (byte_val),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: rtl/dlmr_chk.sv
module dlmr_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              in_valid,
  input logic              msg_mode,
  input logic              irq,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_data,
  input logic              flag_hit
);
  a_r1_disable_forces_hdlc: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !msg_mode);

  a_r2_entry_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_mode) |-> $past(en));

  a_r3_exit_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msg_mode) |-> (!$past(en) || $past(flag_hit)));

  a_r5_edge_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!out_data[0] && !out_data[BYTE_W-1]));

  a_r7_irq_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r7_irq_from_msg_mode: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(msg_mode));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r9_idle_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && en) |=> $stable(msg_mode));
endmodule

bind dl_msg_rx dlmr_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .in_valid  (in_valid),
  .msg_mode  (msg_mode),
  .irq       (irq),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .flag_hit  (flag_hit)
);

// File: tb/dl_msg_rx_tb.sv
`timescale 1ns/1ps
module dl_msg_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       out_ready = 1'b1;
  logic       msg_mode;
  logic       out_valid;
  logic [7:0] out_data;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  dl_msg_rx u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_bit(in_bit),
    .msg_mode(msg_mode), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Every task starts and ends one time unit after a rising edge.
  task automatic send_bit(input logic b);
    in_valid = 1'b1;
    in_bit   = b;
    @(posedge clk); #1;
  endtask

  task automatic idle(input logic b);
    in_valid = 1'b0;
    in_bit   = b;
    @(posedge clk); #1;
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_msg(input logic [7:0] v, input bit expect_store);
    if (expect_store) exp_q.push_back(v);
    send_ones(8);
    send_byte(v);
  endtask

  // Scoreboard monitor: compares each handshaken byte.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R5/R8 unexpected byte: actual %0h expected none", out_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (out_data !== e) begin
          n_fail++;
          $display("FAIL R6 byte value: actual %0h expected %0h", out_data, e);
        end
      end
    end
    if (rst_n && irq) irq_cnt++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 reset msg_mode", msg_mode, 0);
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 reset irq", irq, 0);

    en = 1'b1;
    send_zeros(4);
    send_ones(7);
    chk("R2 seven ones stay HDLC", msg_mode, 0);
    for (int i = 0; i < 3; i++) idle(1'b1);
    chk("R9 idle ones not counted", msg_mode, 0);
    send_bit(1'b1);
    chk("R2 eighth one enters message mode", msg_mode, 1);

    // The entry run is not used as sync.
    send_byte(8'h44);
    chk("R4 entry run gives no byte", out_valid, 0);

    send_msg(8'h1A, 1'b1);
    chk("R6 out_valid after last bit", out_valid, 1);
    chk("R6 bit order", out_data, 8'h1A);
    idle(1'b0);

    send_msg(8'h03, 1'b0);          // first bit 1
    chk("R5 first bit one dropped", out_valid, 0);
    send_msg(8'h80, 1'b0);          // last bit 1
    send_bit(1'b0);
    chk("R5 last bit one dropped", out_valid, 0);

    // Watchdog: sync, then only zeros. The first eight zeros form byte 0x00.
    chk("R7 no irq before window", irq_cnt, 0);
    exp_q.push_back(8'h00);
    send_ones(8);
    send_zeros(31);
    chk("R7 no irq at 31 bits", irq, 0);
    send_zeros(1);
    chk("R7 irq at 32 bits", irq, 1);
    send_zeros(1);
    chk("R7 irq one cycle", irq, 0);
    send_zeros(30);
    chk("R7 no irq at 63 bits", irq, 0);
    send_zeros(1);
    chk("R7 irq again at 64 bits", irq, 1);
    chk("R7 irq count", irq_cnt, 1);
    idle(1'b0);
    chk("R7 irq count after second", irq_cnt, 2);
    chk("R7 still message mode", msg_mode, 1);
    send_msg(8'h3C, 1'b1);
    chk("R7 sampling continues", out_data, 8'h3C);

    // Flag at an arbitrary alignment returns to HDLC.
    send_zeros(3);
    send_bit(1'b0);
    send_ones(6);
    chk("R3 before flag end", msg_mode, 1);
    send_bit(1'b0);
    chk("R3 flag returns to HDLC", msg_mode, 0);

    send_ones(8);
    chk("R2 re-entry", msg_mode, 1);
    // Candidate 0x7E is also a flag: flag wins.
    send_ones(8);
    send_byte(8'h7E);
    chk("R10 flag wins mode", msg_mode, 0);
    chk("R10 flag wins no byte", out_valid, 0);

    // Back-pressure.
    send_ones(8);
    chk("R2 re-entry 2", msg_mode, 1);
    out_ready = 1'b0;
    send_msg(8'h24, 1'b1);
    chk("R8 byte held valid", out_valid, 1);
    send_msg(8'h42, 1'b0);
    chk("R8 still valid", out_valid, 1);
    chk("R8 held data unchanged", out_data, 8'h24);
    idle(1'b0);
    out_ready = 1'b1;
    idle(1'b0);
    idle(1'b0);
    chk("R8 dropped byte not offered", out_valid, 0);
    chk("R8 scoreboard drained", exp_q.size(), 0);

    // Disable.
    en = 1'b0;
    send_bit(1'b0);
    chk("R1 disable returns HDLC", msg_mode, 0);
    send_msg(8'h18, 1'b0);
    send_zeros(40);
    chk("R1 disabled no mode", msg_mode, 0);
    chk("R1 disabled no byte", out_valid, 0);
    chk("R1 disabled no irq", irq_cnt, 2);
    idle(1'b0);
    chk("R6 all expected bytes seen", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule